// File: doc/BRIEF.md
# USB Endpoint Handshake Decision Unit

This unit keeps the control word for each of up to eight device endpoints and picks the reply to every decoded token. The packet engine presents a token type (SETUP, IN or OUT) and an endpoint number. The unit answers with a handshake code one cycle later: no reply, ACK, NAK or STALL. When the token starts a data transfer, the unit waits for the engine's transaction-complete strobe. It then disarms the endpoint. Each endpoint has sticky status flags, and there is one device-level interrupt flag per endpoint. An interrupt request is raised from NAK events.

Software programs the control words, and reads or clears the flags, through a small register port. Writes take effect at the clock edge. Reads are combinational. The decision logic is a two-state machine. `ST_IDLE` accepts tokens. On a reply that opens a data transfer (transition `GO_XFER`) it moves to `ST_XFER`. All other outcomes use transition `STAY_IDLE`. `ST_XFER` ignores tokens. When the complete strobe arrives (transition `DONE`) it clears the endpoint's arm bit and returns to `ST_IDLE`.

Register map on `reg_addr`:
- 0..7: control word of endpoint n. Bit 0 arm, bit 1 enable, bit 2 direction (1 = OUT expected, 0 = IN expected), bit 3 NAK interrupt enable, bit 4 isochronous, bit 5 stall. Bits 7:6 are reserved and read 0.
- 8..15: status of endpoint n-8, write 1 to clear. Bit 0 setup, bit 1 IN exception, bit 2 OUT exception, bit 3 NAK.
- 16: device endpoint interrupt enable, one bit per endpoint.
- 17: device endpoint interrupt flag, one bit per endpoint, write 1 to clear.

Token codes on `tok_kind`: 0 none, 1 OUT, 2 IN, 3 SETUP. Handshake codes on `hs_code`: 0 none, 1 ACK, 2 NAK, 3 STALL.

Top module: `ep_hs_ctrl`

## Requirements
- R1: A token to an endpoint whose enable bit is 0 produces no `hs_valid` and changes no status or device flag.
- R2: An OUT or IN token to an enabled endpoint whose arm bit is 0 and stall bit is 0 gets NAK (code 2) on the cycle after the token.
- R3: A SETUP token to an enabled endpoint gets ACK (code 1) and sets status bit 0, whatever the arm, direction and stall bits are. The unit then enters `ST_XFER`.
- R4: An armed endpoint that sees a token against its direction bit (1 = OUT) answers NAK. An IN token sets status bit 1, and an OUT token sets status bit 2.
- R5: An armed, enabled, non-stalled, non-isochronous endpoint whose direction matches gets ACK, and the unit enters `ST_XFER`.
- R6: `xfer_done` in `ST_XFER` clears the arm bit (control bit 0) of the endpoint being transferred.
- R7: With stall bit 5 set, a non-SETUP token to an enabled endpoint gets STALL (code 3), in preference to NAK.
- R8: On endpoints 1 to 7, a matching armed transfer with isochronous bit 4 set gives `hs_valid` with code 0. On endpoint 0, bit 4 has no effect.
- R9: Every NAK sets status bit 3 of that endpoint and its bit in the device interrupt flag register (address 17).
- R10: `irq` is 1 exactly when some endpoint has its device flag, its device interrupt enable (address 16) and its NAK interrupt enable (control bit 3) all set. Writing 1 to a device flag bit clears it.
- R11: Control bits 7:6 always read back as 0.
- R12: Tokens that arrive in `ST_XFER` get no reply and change no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tok_valid | input | 1 | Token present this cycle |
| tok_kind | input | 2 | Token type: 1 OUT, 2 IN, 3 SETUP |
| tok_ep | input | 3 | Endpoint number of the token |
| xfer_done | input | 1 | Transaction-complete strobe from the packet engine |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| hs_valid | output | 1 | Reply decided for the previous cycle's token |
| hs_code | output | 2 | Reply code: 0 none, 1 ACK, 2 NAK, 3 STALL |
| irq | output | 1 | Endpoint interrupt request |

## Verification
A handshake is registered, so it appears one clock after the token. Flag and arm updates land on the same edge, and `reg_rdata` follows them with no extra delay because reads are combinational. The bench drives a token on a falling edge and samples `hs_valid`, `hs_code`, read data and `irq` on the next falling edge, half a cycle after the deciding rising edge. An arm-bit clear is checked one falling edge after `xfer_done` is driven. An `irq` change is checked combinationally, a short delay after the register write edge.

// File: rtl/ep_hs_pkg.sv
package ep_hs_pkg;
    localparam int EP_W  = 3;
    localparam int N_EP  = 1 << EP_W;
    localparam int DW    = 8;
    localparam int AW    = EP_W + 2;
    localparam int SFW   = 4;

    localparam int C_ARM    = 0;
    localparam int C_EN     = 1;
    localparam int C_DIROUT = 2;
    localparam int C_NAKIE  = 3;
    localparam int C_ISO    = 4;
    localparam int C_STALL  = 5;
    localparam logic [DW-1:0] CTRL_MASK = 8'h3F;

    localparam int F_SETUP = 0;
    localparam int F_INX   = 1;
    localparam int F_OUTX  = 2;
    localparam int F_NAK   = 3;

    typedef enum logic [1:0] {
        TK_NONE  = 2'd0,
        TK_OUT   = 2'd1,
        TK_IN    = 2'd2,
        TK_SETUP = 2'd3
    } tok_e;

    typedef enum logic [1:0] {
        HS_NONE  = 2'd0,
        HS_ACK   = 2'd1,
        HS_NAK   = 2'd2,
        HS_STALL = 2'd3
    } hs_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_XFER = 1'b1
    } st_e;
endpackage

// File: rtl/ep_hs_regs.sv
module ep_hs_regs
    import ep_hs_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr,
    input  logic [AW-1:0]            addr,
    input  logic [DW-1:0]            wdata,
    output logic [DW-1:0]            rdata,
    input  logic                     evt_valid,
    input  logic [EP_W-1:0]          evt_ep,
    input  logic [SFW-1:0]           evt_flags,
    input  logic                     arm_clr,
    input  logic [EP_W-1:0]          arm_ep,
    output logic [N_EP-1:0][DW-1:0]  ctrl,
    output logic                     irq
);
    localparam logic [AW-1:0] A_DIE  = AW'(2 * N_EP);
    localparam logic [AW-1:0] A_DFLG = AW'(2 * N_EP + 1);

    logic [N_EP-1:0][SFW-1:0] stat;
    logic [N_EP-1:0]          dev_ie;
    logic [N_EP-1:0]          dev_flag;
    logic [N_EP-1:0]          nak_ie;

    for (genvar i = 0; i < N_EP; i++) begin : g_ep
        logic hit_c, hit_s, hit_e;
        assign hit_c = wr && (addr == AW'(i));
        assign hit_s = wr && (addr == AW'(N_EP + i));
        assign hit_e = evt_valid && (evt_ep == EP_W'(i));
        assign nak_ie[i] = ctrl[i][C_NAKIE];

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ctrl[i] <= '0;
                stat[i] <= '0;
            end else begin
                if (hit_c)
                    ctrl[i] <= wdata & CTRL_MASK;
                if (arm_clr && arm_ep == EP_W'(i))
                    ctrl[i][C_ARM] <= 1'b0;
                stat[i] <= (stat[i] & ~(hit_s ? wdata[SFW-1:0] : '0))
                         | (hit_e ? evt_flags : '0);
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n)
                dev_flag[i] <= 1'b0;
            else if (hit_e && evt_flags[F_NAK])
                dev_flag[i] <= 1'b1;
            else if (wr && addr == A_DFLG && wdata[i])
                dev_flag[i] <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            dev_ie <= '0;
        else if (wr && addr == A_DIE)
            dev_ie <= wdata[N_EP-1:0];
    end

    always_comb begin
        rdata = '0;
        if (addr < AW'(N_EP))
            rdata = ctrl[addr[EP_W-1:0]];
        else if (addr < AW'(2 * N_EP))
            rdata = DW'(stat[addr[EP_W-1:0]]);
        else if (addr == A_DIE)
            rdata = DW'(dev_ie);
        else if (addr == A_DFLG)
            rdata = DW'(dev_flag);
    end

    assign irq = |(dev_flag & dev_ie & nak_ie);

    // R6
    arm_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arm_clr |=> !ctrl[$past(arm_ep)][C_ARM]);

    // R9
    nak_devflag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_flags[F_NAK]) |=> dev_flag[$past(evt_ep)]);

    // R11
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr < AW'(N_EP)) |-> (rdata[DW-1:6] == '0));
endmodule

// File: rtl/ep_hs_fsm.sv
module ep_hs_fsm
    import ep_hs_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tok_valid,
    input  logic [1:0]      tok_kind,
    input  logic [EP_W-1:0] tok_ep,
    input  logic [DW-1:0]   ep_ctrl,
    input  logic            xfer_done,
    output logic            hs_valid,
    output logic [1:0]      hs_code,
    output logic            evt_valid,
    output logic [EP_W-1:0] evt_ep,
    output logic [SFW-1:0]  evt_flags,
    output logic            arm_clr,
    output logic [EP_W-1:0] arm_ep
);
    st_e             st, st_nx;
    logic [EP_W-1:0] cur_ep;
    logic            accept, reply, go;
    hs_e             code;
    tok_e            kind;

    assign kind   = tok_e'(tok_kind);
    assign accept = tok_valid && (st == ST_IDLE) && (kind != TK_NONE)
                    && ep_ctrl[C_EN];

    always_comb begin
        reply     = 1'b0;
        go        = 1'b0;
        code      = HS_NONE;
        evt_flags = '0;
        if (accept) begin
            reply = 1'b1;
            if (kind == TK_SETUP) begin
                code = HS_ACK;
                go   = 1'b1;
                evt_flags[F_SETUP] = 1'b1;
            end else if (ep_ctrl[C_STALL]) begin
                code = HS_STALL;
            end else if (!ep_ctrl[C_ARM]) begin
                code = HS_NAK;
                evt_flags[F_NAK] = 1'b1;
            end else if ((kind == TK_OUT) != ep_ctrl[C_DIROUT]) begin
                code = HS_NAK;
                evt_flags[F_NAK] = 1'b1;
                if (kind == TK_IN) evt_flags[F_INX]  = 1'b1;
                else               evt_flags[F_OUTX] = 1'b1;
            end else begin
                go   = 1'b1;
                code = (ep_ctrl[C_ISO] && tok_ep != '0) ? HS_NONE : HS_ACK;
            end
        end
    end

    assign evt_valid = accept;
    assign evt_ep    = tok_ep;
    assign arm_clr   = (st == ST_XFER) && xfer_done;
    assign arm_ep    = cur_ep;

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE: if (go)        st_nx = ST_XFER;
            ST_XFER: if (xfer_done) st_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_valid <= 1'b0;
            hs_code  <= HS_NONE;
            cur_ep   <= '0;
        end else begin
            hs_valid <= reply;
            hs_code  <= code;
            if (go) cur_ep <= tok_ep;
        end
    end

    // R1
    disabled_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_valid && !ep_ctrl[C_EN]) |=> !hs_valid);

    // R3
    setup_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_valid && st == ST_IDLE && kind == TK_SETUP && ep_ctrl[C_EN])
        |=> (hs_valid && hs_code == HS_ACK && st == ST_XFER));

    // R7
    stall_pri_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_valid && st == ST_IDLE && ep_ctrl[C_EN] && ep_ctrl[C_STALL]
         && (kind == TK_IN || kind == TK_OUT)) |=> (hs_code == HS_STALL));

    // R12
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_XFER) |=> !hs_valid);
endmodule

// File: rtl/ep_hs_ctrl.sv
module ep_hs_ctrl
    import ep_hs_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tok_valid,
    input  logic [1:0]      tok_kind,
    input  logic [EP_W-1:0] tok_ep,
    input  logic            xfer_done,
    input  logic            reg_wr,
    input  logic [AW-1:0]   reg_addr,
    input  logic [DW-1:0]   reg_wdata,
    output logic [DW-1:0]   reg_rdata,
    output logic            hs_valid,
    output logic [1:0]      hs_code,
    output logic            irq
);
    logic [N_EP-1:0][DW-1:0] ctrl;
    logic                    evt_valid, arm_clr;
    logic [EP_W-1:0]         evt_ep, arm_ep;
    logic [SFW-1:0]          evt_flags;

    ep_hs_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tok_valid (tok_valid),
        .tok_kind  (tok_kind),
        .tok_ep    (tok_ep),
        .ep_ctrl   (ctrl[tok_ep]),
        .xfer_done (xfer_done),
        .hs_valid  (hs_valid),
        .hs_code   (hs_code),
        .evt_valid (evt_valid),
        .evt_ep    (evt_ep),
        .evt_flags (evt_flags),
        .arm_clr   (arm_clr),
        .arm_ep    (arm_ep)
    );

    ep_hs_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (reg_wr),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .rdata     (reg_rdata),
        .evt_valid (evt_valid),
        .evt_ep    (evt_ep),
        .evt_flags (evt_flags),
        .arm_clr   (arm_clr),
        .arm_ep    (arm_ep),
        .ctrl      (ctrl),
        .irq       (irq)
    );
endmodule

// File: tb/test_ep_hs_ctrl.sv
module test_ep_hs_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tok_valid = 1'b0;
    logic [1:0] tok_kind = 2'd0;
    logic [2:0] tok_ep = 3'd0;
    logic       xfer_done = 1'b0;
    logic       reg_wr = 1'b0;
    logic [4:0] reg_addr = 5'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       hs_valid;
    logic [1:0] hs_code;
    logic       irq;
    int         n_chk = 0;
    int         n_bad = 0;

    always #2 clk = ~clk;

    ep_hs_ctrl i_ep_hs_ctrl (.*);

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 5'(a); reg_wdata = 8'(d);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input string req, input int a, input int exp);
        @(negedge clk);
        reg_addr = 5'(a);
        #1;
        chk(req, int'(reg_rdata), exp);
    endtask

    // send token; returns {hs_valid, hs_code}
    task automatic tok(input int k, input int ep, output int res);
        @(negedge clk);
        tok_valid = 1'b1; tok_kind = 2'(k); tok_ep = 3'(ep);
        @(negedge clk);
        tok_valid = 1'b0;
        res = {29'd0, hs_valid, hs_code};
    endtask

    task automatic done();
        @(negedge clk);
        xfer_done = 1'b1;
        @(negedge clk);
        xfer_done = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 reset hs_valid", int'(hs_valid), 0);
        chk("R10 reset irq", int'(irq), 0);
        rd("R1 reset ctrl", 0, 0);
    endtask

    task automatic t_disabled();
        int r;
        wr(2, 8'h01);               // armed but not enabled
        tok(1, 2, r);
        chk("R1 disabled no reply", r, 0);
        rd("R1 disabled status", 10, 0);
        rd("R1 disabled devflag", 17, 0);
    endtask

    task automatic t_nak_unarmed();
        int r;
        wr(1, 8'h06);               // enable, dir OUT, unarmed
        tok(1, 1, r);
        chk("R2 unarmed NAK", r, 6);
        rd("R9 nak status", 9, 8);
        rd("R9 devflag", 17, 8'h02);
        wr(9, 8'h0F);
        wr(17, 8'hFF);
        rd("R9 w1c status", 9, 0);
    endtask

    task automatic t_setup();
        int r;
        wr(0, 8'h22);               // enable + stall, IN dir, unarmed
        tok(3, 0, r);
        chk("R3 setup ACK", r, 5);
        rd("R3 setup flag", 8, 1);
        tok(1, 0, r);
        chk("R12 busy ignore", r, 0);
        rd("R12 busy no flag", 8, 1);
        done();
        wr(8, 8'h0F);
    endtask

    task automatic t_ack_clear();
        int r;
        wr(4, 8'h07);               // enable, OUT, armed
        tok(1, 4, r);
        chk("R5 armed ACK", r, 5);
        done();
        rd("R6 arm cleared", 4, 8'h06);
        tok(1, 4, r);
        chk("R2 after done NAK", r, 6);
        wr(12, 8'h0F); wr(17, 8'hFF);
    endtask

    task automatic t_mismatch();
        int r;
        wr(5, 8'h07);               // OUT expected, armed
        tok(2, 5, r);
        chk("R4 IN mismatch NAK", r, 6);
        rd("R4 IN exc flag", 13, 8'h0A);
        wr(5, 8'h03);               // IN expected, armed
        tok(1, 5, r);
        chk("R4 OUT mismatch NAK", r, 6);
        rd("R4 OUT exc flag", 13, 8'h0E);
        wr(13, 8'h0F); wr(17, 8'hFF);
    endtask

    task automatic t_stall();
        int r;
        wr(6, 8'h22);               // enable + stall, unarmed
        tok(2, 6, r);
        chk("R7 stall over NAK", r, 7);
        rd("R7 no nak flag", 14, 0);
    endtask

    task automatic t_iso();
        int r;
        wr(3, 8'h13);               // iso, enable, IN, armed
        tok(2, 3, r);
        chk("R8 iso no handshake", r, 4);
        done();
        wr(0, 8'h13);               // iso bit on ep0 ignored
        tok(2, 0, r);
        chk("R8 ep0 iso ACK", r, 5);
        done();
    endtask

    task automatic t_irq();
        int r;
        wr(7, 8'h0A);               // nak ie + enable, unarmed
        wr(16, 8'h80);
        chk("R10 irq idle", int'(irq), 0);
        tok(2, 7, r);
        chk("R9 NAK ep7", r, 6);
        #1 chk("R10 irq set", int'(irq), 1);
        wr(17, 8'h80);
        #1 chk("R10 irq cleared", int'(irq), 0);
        wr(7, 8'h02);
        tok(2, 7, r);
        #1 chk("R10 no irq without nak ie", int'(irq), 0);
        rd("R9 devflag still set", 17, 8'h80);
    endtask

    task automatic t_reserved();
        wr(2, 8'hFF);
        rd("R11 reserved zero", 2, 8'h3F);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_disabled();
        t_nak_unarmed();
        t_setup();
        t_ack_clear();
        t_mismatch();
        t_stall();
        t_iso();
        t_irq();
        t_reserved();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #100000;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule